// File: doc/BRIEF.md
# Sv39 Set-Associative Translation Lookaside Buffer

This block caches virtual-to-physical translations for a 39-bit virtual address space that is paged through a three-level table. A 39-bit virtual address splits into a 27-bit virtual page number (VPN) and a 12-bit page offset. A translation maps the VPN to a 44-bit physical page number (PPN), giving a 56-bit physical address. Base 4 KB pages live in a set-indexed array. The number of sets and the number of ways are separate power-of-two parameters, so one design covers direct-mapped (one way), set-associative and fully-associative (one set) shapes. 2 MB and 1 GB pages live in a small fully-associative side array.

A client presents a lookup and gets a registered result one cycle later: hit or miss, the physical address and the permission bits. A miss also raises a request, carrying the VPN, to an external table walker. The walker answers by writing a refill entry. A flush input empties the whole buffer in one cycle. Victim selection in the base array is chosen at elaboration: tree pseudo-LRU with per-set state, or a pseudo-random sequence.

Top module: `sv39_tlb`

## Requirements
- R1: A base-page hit returns `{PPN, va[11:0]}` as the physical address. The set index is VPN[log2(SETS)-1:0] and the tag is the rest of the VPN. Entries in another set, or with another tag in the same set, do not hit.
- R2: `res_valid` is high exactly one cycle after `lk_valid` was high. The result describes the contents seen at the request edge, and `res_hit` is never high without `res_valid`.
- R3: A lookup that misses sets `miss_req` in its result cycle, with `miss_vpn` equal to VA[38:12] of that lookup.
- R4: A refill into a set that has an invalid way uses the lowest-numbered invalid way, so it evicts nothing. At most one entry is written per refill.
- R5: With pseudo-LRU selected and the set full, a refill evicts the way least recently touched. A hit and a refill each count as a touch. For two ways this is the exact LRU way.
- R6: A refill with `fill_level`=1 stores a 2 MB page. A lookup matches it on VPN[26:9] alone, and PPN[8:0] of the result is taken from VPN[8:0] of the lookup.
- R7: A refill with `fill_level`=2 (or 3) stores a 1 GB page. A lookup matches it on VPN[26:18] alone, and PPN[17:0] of the result is taken from VPN[17:0] of the lookup.
- R8: `res_perm` returns the stored permission bits of the hit entry. The encoding is bit0 read, bit1 write, bit2 execute, bit3 user, bit4 accessed, bit5 dirty. `fill_level`=0 means a 4 KB page.
- R9: A lookup hits only when exactly one valid entry, base or superpage, matches. Two matching entries give a miss.
- R10: `flush_all` invalidates every base and superpage entry at the next edge. A refill in the same cycle is dropped.
- R11: After reset no entry is valid, and `res_valid`, `res_hit` and `miss_req` are low.
- R12: A fully-associative build (SETS=1) holds WAYS base pages at once. A further refill evicts exactly one of them, including under random replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 39 | Virtual address to translate |
| flush_all | input | 1 | Invalidate every entry |
| fill_valid | input | 1 | Refill entry strobe |
| fill_vpn | input | 27 | VPN of the refill |
| fill_ppn | input | 44 | PPN of the refill |
| fill_level | input | 2 | Page size: 0 4 KB, 1 2 MB, 2/3 1 GB |
| fill_perm | input | 6 | Permission bits {D,A,U,X,W,R} |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_hit | output | 1 | Lookup hit |
| res_pa | output | 56 | Translated physical address |
| res_perm | output | 6 | Permission bits of the hit entry |
| miss_req | output | 1 | Refill request to the table walker |
| miss_vpn | output | 27 | VPN to be walked |

## Verification
The bench builds two copies. The first uses four sets, two ways and pseudo-LRU. Its small sets fill in two refills, so invalid-way preference, exact LRU eviction, set isolation, duplicate-match misses and both superpage sizes can all be reached with a few dozen vectors. The second uses one set, four ways and random replacement. It exercises the zero-width index path and shows that a full fully-associative array loses exactly one entry per refill, whatever the random victim turns out to be.

// File: rtl/sv39_tlb_pkg.sv
package sv39_tlb_pkg;
  localparam int VA_W   = 39;
  localparam int VPN_W  = 27;
  localparam int PPN_W  = 44;
  localparam int OFF_W  = 12;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int PERM_W = 6;
  localparam int LVL_W  = 2;

  // Superpage tag compare: 2 MB ignores VPN[8:0], 1 GB ignores VPN[17:0]
  function automatic logic super_hit(input logic [VPN_W-1:0] stored,
                                     input logic [VPN_W-1:0] probe,
                                     input logic             giga);
    if (giga) return stored[VPN_W-1:18] == probe[VPN_W-1:18];
    return stored[VPN_W-1:9] == probe[VPN_W-1:9];
  endfunction

  // Untranslated VPN bits fill the low PPN bits of a superpage
  function automatic logic [PPN_W-1:0] super_ppn(input logic [PPN_W-1:0] ppn,
                                                 input logic [VPN_W-1:0] probe,
                                                 input logic             giga);
    if (giga) return {ppn[PPN_W-1:18], probe[17:0]};
    return {ppn[PPN_W-1:9], probe[8:0]};
  endfunction
endpackage

// File: rtl/tlb_repl.sv
module tlb_repl #(
  parameter int SETS     = 16,
  parameter int WAYS     = 4,
  parameter bit USE_PLRU = 1'b1,
  localparam int IB = $clog2(SETS),
  localparam int IW = (IB == 0) ? 1 : IB,
  localparam int LW = $clog2(WAYS),
  localparam int WW = (LW == 0) ? 1 : LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_en,
  input  logic [IW-1:0] hit_set,
  input  logic [WW-1:0] hit_way,
  input  logic          fill_en,
  input  logic [IW-1:0] fill_set,
  input  logic [WW-1:0] fill_way,
  output logic [WW-1:0] victim_way
);
  localparam int TW = (WAYS > 1) ? WAYS - 1 : 1;

  // Heap-ordered tree: node n at bit n-1, bit 1 points to right subtree
  function automatic logic [WW-1:0] tree_pick(input logic [TW-1:0] t);
    int node;
    node = 1;
    for (int l = 0; l < LW; l++) node = 2 * node + int'(t[node-1]);
    return WW'(node - WAYS);
  endfunction

  function automatic logic [TW-1:0] tree_touch(input logic [TW-1:0] t,
                                               input logic [WW-1:0] w);
    logic [TW-1:0] r;
    logic          dir;
    int            node;
    r    = t;
    node = 1;
    for (int l = 0; l < LW; l++) begin
      dir       = w[LW-1-l];
      r[node-1] = ~dir;
      node      = 2 * node + int'(dir);
    end
    return r;
  endfunction

  generate
    if (WAYS == 1) begin : g_single
      logic unused_repl_in;
      assign unused_repl_in = ^{hit_en, hit_set, hit_way, fill_en, fill_set,
                                fill_way, clk, rst_n};
      assign victim_way = '0;
    end else if (USE_PLRU) begin : g_plru
      logic [TW-1:0] tree     [SETS];
      logic [TW-1:0] tree_nxt [SETS];
      always_comb begin
        tree_nxt = tree;
        if (hit_en)  tree_nxt[hit_set]  = tree_touch(tree_nxt[hit_set], hit_way);
        if (fill_en) tree_nxt[fill_set] = tree_touch(tree_nxt[fill_set], fill_way);
      end
      always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
          if (!rst_n) tree[s] <= '0;
          else        tree[s] <= tree_nxt[s];
        end
      end
      assign victim_way = tree_pick(tree[fill_set]);
    end else begin : g_rand
      logic [15:0] lfsr;
      logic        unused_rand_in;
      assign unused_rand_in = ^{hit_en, hit_set, hit_way, fill_en, fill_set, fill_way};
      always_ff @(posedge clk) begin
        if (!rst_n) lfsr <= 16'hACE1;
        else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      end
      assign victim_way = lfsr[WW-1:0];
    end
  endgenerate
endmodule

// File: rtl/tlb_base_array.sv
module tlb_base_array
  import sv39_tlb_pkg::*;
#(
  parameter int SETS     = 16,
  parameter int WAYS     = 4,
  parameter bit USE_PLRU = 1'b1,
  localparam int IB = $clog2(SETS),
  localparam int IW = (IB == 0) ? 1 : IB,
  localparam int LW = $clog2(WAYS),
  localparam int WW = (LW == 0) ? 1 : LW,
  localparam int TAG_W = VPN_W - IB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              touch_ok,
  output logic [WAYS-1:0]   match,
  output logic [PPN_W-1:0]  m_ppn,
  output logic [PERM_W-1:0] m_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  output logic [WAYS-1:0]   fill_oh
);
  function automatic logic [IW-1:0] set_of(input logic [VPN_W-1:0] v);
    if (IB == 0) return '0;
    return v[IW-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] v);
    return v[VPN_W-1:IB];
  endfunction

  logic              vld  [SETS][WAYS];
  logic [TAG_W-1:0]  tag  [SETS][WAYS];
  logic [PPN_W-1:0]  ppn  [SETS][WAYS];
  logic [PERM_W-1:0] perm [SETS][WAYS];

  logic [IW-1:0] lk_set, f_set;
  logic [WW-1:0] hit_way, victim, inv_way, fill_way;
  logic          has_inv, hit_en, wr_en;

  assign lk_set = set_of(lk_vpn);
  assign f_set  = set_of(fill_vpn);
  assign wr_en  = fill_en && !flush;

  always_comb begin
    m_ppn   = '0;
    m_perm  = '0;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      match[w] = vld[lk_set][w] && (tag[lk_set][w] == tag_of(lk_vpn));
      m_ppn    = m_ppn  | ({PPN_W{match[w]}} & ppn[lk_set][w]);
      m_perm   = m_perm | ({PERM_W{match[w]}} & perm[lk_set][w]);
      if (match[w]) hit_way = WW'(w);
    end
  end
  assign hit_en = lk_valid && touch_ok && (|match);

  always_comb begin
    has_inv = 1'b0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vld[f_set][w]) begin
        has_inv = 1'b1;
        inv_way = WW'(w);
      end
    end
    fill_way = has_inv ? inv_way : victim;
    for (int w = 0; w < WAYS; w++) fill_oh[w] = wr_en && (fill_way == WW'(w));
  end

  tlb_repl #(.SETS(SETS), .WAYS(WAYS), .USE_PLRU(USE_PLRU)) u_repl (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_en    (hit_en),
    .hit_set   (lk_set),
    .hit_way   (hit_way),
    .fill_en   (wr_en),
    .fill_set  (f_set),
    .fill_way  (fill_way),
    .victim_way(victim)
  );

  always_ff @(posedge clk) begin
    for (int s = 0; s < SETS; s++) begin
      for (int w = 0; w < WAYS; w++) begin
        if (!rst_n || flush)                             vld[s][w] <= 1'b0;
        else if (fill_oh[w] && (f_set == IW'(s)))        vld[s][w] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (fill_oh[w]) begin
        tag[f_set][w]  <= tag_of(fill_vpn);
        ppn[f_set][w]  <= fill_ppn;
        perm[f_set][w] <= fill_perm;
      end
    end
  end
endmodule

// File: rtl/tlb_super_array.sv
module tlb_super_array
  import sv39_tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int EB = $clog2(ENTRIES),
  localparam int EW = (EB == 0) ? 1 : EB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [VPN_W-1:0]    lk_vpn,
  output logic [ENTRIES-1:0]  match,
  output logic [PPN_W-1:0]    m_ppn,
  output logic [PERM_W-1:0]   m_perm,
  input  logic                fill_en,
  input  logic                fill_giga,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [PPN_W-1:0]    fill_ppn,
  input  logic [PERM_W-1:0]   fill_perm,
  output logic [ENTRIES-1:0]  fill_oh
);
  logic              vld  [ENTRIES];
  logic              giga [ENTRIES];
  logic [VPN_W-1:0]  vpn  [ENTRIES];
  logic [PPN_W-1:0]  ppn  [ENTRIES];
  logic [PERM_W-1:0] perm [ENTRIES];

  logic [EW-1:0] rr, inv_slot, slot;
  logic          has_inv, wr_en;

  assign wr_en = fill_en && !flush;

  always_comb begin
    m_ppn  = '0;
    m_perm = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      match[e] = vld[e] && super_hit(vpn[e], lk_vpn, giga[e]);
      m_ppn    = m_ppn  | ({PPN_W{match[e]}} & super_ppn(ppn[e], lk_vpn, giga[e]));
      m_perm   = m_perm | ({PERM_W{match[e]}} & perm[e]);
    end
  end

  always_comb begin
    has_inv  = 1'b0;
    inv_slot = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (!vld[e]) begin
        has_inv  = 1'b1;
        inv_slot = EW'(e);
      end
    end
    slot = has_inv ? inv_slot : rr;
    for (int e = 0; e < ENTRIES; e++) fill_oh[e] = wr_en && (slot == EW'(e));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr <= '0;
    else if (wr_en && !has_inv) rr <= (rr == EW'(ENTRIES - 1)) ? '0 : rr + 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (!rst_n || flush) vld[e] <= 1'b0;
      else if (fill_oh[e]) vld[e] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (fill_oh[e]) begin
        giga[e] <= fill_giga;
        vpn[e]  <= fill_vpn;
        ppn[e]  <= fill_ppn;
        perm[e] <= fill_perm;
      end
    end
  end
endmodule

// File: rtl/sv39_tlb.sv
module sv39_tlb
  import sv39_tlb_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int SP_ENTRIES = 8,
  parameter bit USE_PLRU   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_va,
  input  logic              flush_all,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [LVL_W-1:0]  fill_level,
  input  logic [PERM_W-1:0] fill_perm,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PA_W-1:0]   res_pa,
  output logic [PERM_W-1:0] res_perm,
  output logic              miss_req,
  output logic [VPN_W-1:0]  miss_vpn
);
  logic [VPN_W-1:0]      lk_vpn;
  logic [WAYS-1:0]       b_match;
  logic [SP_ENTRIES-1:0] s_match;
  logic [PPN_W-1:0]      b_ppn, s_ppn;
  logic [PERM_W-1:0]     b_perm, s_perm;
  logic                  lookup_single;
  logic                  base_fill, super_fill;
  logic [WAYS-1:0]       fill_base_oh;
  logic [SP_ENTRIES-1:0] fill_super_oh;

  assign lk_vpn        = lk_va[VA_W-1:OFF_W];
  assign lookup_single = ($countones(b_match) + $countones(s_match)) == 1;
  assign base_fill     = fill_valid && (fill_level == 2'd0);
  assign super_fill    = fill_valid && (fill_level != 2'd0);

  tlb_base_array #(.SETS(SETS), .WAYS(WAYS), .USE_PLRU(USE_PLRU)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_all),
    .lk_valid (lk_valid),
    .lk_vpn   (lk_vpn),
    .touch_ok (lookup_single),
    .match    (b_match),
    .m_ppn    (b_ppn),
    .m_perm   (b_perm),
    .fill_en  (base_fill),
    .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn),
    .fill_perm(fill_perm),
    .fill_oh  (fill_base_oh)
  );

  tlb_super_array #(.ENTRIES(SP_ENTRIES)) u_super (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_all),
    .lk_vpn   (lk_vpn),
    .match    (s_match),
    .m_ppn    (s_ppn),
    .m_perm   (s_perm),
    .fill_en  (super_fill),
    .fill_giga(fill_level[1]),
    .fill_vpn (fill_vpn),
    .fill_ppn (fill_ppn),
    .fill_perm(fill_perm),
    .fill_oh  (fill_super_oh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      miss_req  <= 1'b0;
      res_pa    <= '0;
      res_perm  <= '0;
      miss_vpn  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && lookup_single;
      miss_req  <= lk_valid && !lookup_single;
      if (lk_valid) begin
        res_pa   <= {(|b_match) ? b_ppn : s_ppn, lk_va[OFF_W-1:0]};
        res_perm <= (|b_match) ? b_perm : s_perm;
        miss_vpn <= lk_vpn;
      end
    end
  end
endmodule

// File: rtl/sv39_tlb_checker.sv
module sv39_tlb_checker #(
  parameter int WAYS       = 4,
  parameter int SP_ENTRIES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lk_valid,
  input logic [38:0]           lk_va,
  input logic                  flush_all,
  input logic                  res_valid,
  input logic                  res_hit,
  input logic [55:0]           res_pa,
  input logic                  miss_req,
  input logic [WAYS-1:0]       fill_base_oh,
  input logic [SP_ENTRIES-1:0] fill_super_oh
);
  p_result_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(lk_valid));

  p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_valid);

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_pa[11:0] == $past(lk_va[11:0]));

  p_miss_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> (res_valid && !res_hit));

  p_single_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fill_base_oh, fill_super_oh}));

  p_flush_drops_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> (fill_base_oh == '0 && fill_super_oh == '0));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_all, 2) && res_valid) |-> !res_hit);
endmodule

bind sv39_tlb sv39_tlb_checker #(.WAYS(WAYS), .SP_ENTRIES(SP_ENTRIES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_va        (lk_va),
  .flush_all    (flush_all),
  .res_valid    (res_valid),
  .res_hit      (res_hit),
  .res_pa       (res_pa),
  .miss_req     (miss_req),
  .fill_base_oh (fill_base_oh),
  .fill_super_oh(fill_super_oh)
);

// File: tb/sv39_tlb_test.sv
module sv39_tlb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        lk1 = 0, lk2 = 0, fv1 = 0, fv2 = 0, fl1 = 0;
  logic [38:0] va = '0;
  logic [26:0] f_vpn = '0;
  logic [43:0] f_ppn = '0;
  logic [1:0]  f_lvl = '0;
  logic [5:0]  f_perm = '0;

  logic        rv1, rh1, mq1, rv2, rh2, mq2;
  logic [55:0] pa1, pa2;
  logic [5:0]  pm1, pm2;
  logic [26:0] mv1, mv2;
  logic        fl2;
  assign fl2 = 1'b0;

  sv39_tlb #(.SETS(4), .WAYS(2), .SP_ENTRIES(2), .USE_PLRU(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk1), .lk_va(va), .flush_all(fl1),
    .fill_valid(fv1), .fill_vpn(f_vpn), .fill_ppn(f_ppn), .fill_level(f_lvl),
    .fill_perm(f_perm), .res_valid(rv1), .res_hit(rh1), .res_pa(pa1),
    .res_perm(pm1), .miss_req(mq1), .miss_vpn(mv1));

  sv39_tlb #(.SETS(1), .WAYS(4), .SP_ENTRIES(2), .USE_PLRU(1'b0)) uut_fa (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk2), .lk_va(va), .flush_all(fl2),
    .fill_valid(fv2), .fill_vpn(f_vpn), .fill_ppn(f_ppn), .fill_level(f_lvl),
    .fill_perm(f_perm), .res_valid(rv2), .res_hit(rh2), .res_pa(pa2),
    .res_perm(pm2), .miss_req(mq2), .miss_vpn(mv2));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Outputs sampled at the negedge after the result edge
  logic        o_hit, o_mreq;
  logic [55:0] o_pa;
  logic [5:0]  o_pm;
  logic [26:0] o_mv;

  task automatic lookup(input bit fa, input logic [26:0] vpn, input logic [11:0] off);
    @(negedge clk);
    va = {vpn, off};
    if (fa) lk2 = 1; else lk1 = 1;
    @(negedge clk);
    lk1 = 0; lk2 = 0;
    o_hit  = fa ? rh2 : rh1;
    o_mreq = fa ? mq2 : mq1;
    o_pa   = fa ? pa2 : pa1;
    o_pm   = fa ? pm2 : pm1;
    o_mv   = fa ? mv2 : mv1;
  endtask

  task automatic refill(input bit fa, input logic [26:0] vpn, input logic [43:0] ppn,
                        input logic [1:0] lvl, input logic [5:0] perm, input bit with_flush);
    @(negedge clk);
    f_vpn = vpn; f_ppn = ppn; f_lvl = lvl; f_perm = perm;
    if (fa) fv2 = 1; else fv1 = 1;
    if (with_flush) fl1 = 1;
    @(negedge clk);
    fv1 = 0; fv2 = 0; fl1 = 0;
  endtask

  localparam logic [1:0] OP_LK = 2'd0, OP_FILL = 2'd1, OP_FLUSH = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [26:0] vpn;
    logic [11:0] off;
    logic [43:0] ppn;
    logic [1:0]  lvl;
    logic [5:0]  perm;
    logic        ehit;
    logic [43:0] eppn;
    logic [5:0]  eperm;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    '{OP_LK,   27'h10,    12'h123, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd3},  // R3 cold miss
    '{OP_FILL, 27'h10,    12'h000, 44'hABC,   2'd0, 6'h3F, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h10,    12'h123, 44'h0,     2'd0, 6'h00, 1'b1, 44'hABC,   6'h3F, 4'd1},  // R1
    '{OP_FILL, 27'h14,    12'h000, 44'h111,   2'd0, 6'h0B, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h14,    12'h7FF, 44'h0,     2'd0, 6'h00, 1'b1, 44'h111,   6'h0B, 4'd8},  // R8 R4
    '{OP_LK,   27'h10,    12'h000, 44'h0,     2'd0, 6'h00, 1'b1, 44'hABC,   6'h3F, 4'd4},  // R4
    '{OP_FILL, 27'h18,    12'h000, 44'h222,   2'd0, 6'h01, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h14,    12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd5},  // R5 LRU evicted
    '{OP_LK,   27'h10,    12'h000, 44'h0,     2'd0, 6'h00, 1'b1, 44'hABC,   6'h3F, 4'd5},
    '{OP_LK,   27'h18,    12'h004, 44'h0,     2'd0, 6'h00, 1'b1, 44'h222,   6'h01, 4'd5},
    '{OP_FILL, 27'h1C,    12'h000, 44'h333,   2'd0, 6'h03, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h10,    12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd5},  // R5
    '{OP_LK,   27'h18,    12'h000, 44'h0,     2'd0, 6'h00, 1'b1, 44'h222,   6'h01, 4'd5},
    '{OP_LK,   27'h1C,    12'h010, 44'h0,     2'd0, 6'h00, 1'b1, 44'h333,   6'h03, 4'd5},
    '{OP_FILL, 27'h11,    12'h000, 44'h444,   2'd0, 6'h05, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h11,    12'hABC, 44'h0,     2'd0, 6'h00, 1'b1, 44'h444,   6'h05, 4'd1},  // R1 set 1
    '{OP_LK,   27'h15,    12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd1},  // R1 tag differs
    '{OP_FILL, 27'h200,   12'h000, 44'h400,   2'd1, 6'h1B, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h2AB,   12'h456, 44'h0,     2'd0, 6'h00, 1'b1, 44'h4AB,   6'h1B, 4'd6},  // R6
    '{OP_LK,   27'h4AB,   12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd6},
    '{OP_FILL, 27'h40000, 12'h000, 44'h80000, 2'd2, 6'h1D, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h7FFFF, 12'hFFF, 44'h0,     2'd0, 6'h00, 1'b1, 44'hBFFFF, 6'h1D, 4'd7},  // R7
    '{OP_LK,   27'h80000, 12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd7},
    '{OP_FILL, 27'h11,    12'h000, 44'h555,   2'd0, 6'h01, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h11,    12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd9},  // R9 duplicate
    '{OP_FLUSH,27'h0,     12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd0},
    '{OP_LK,   27'h18,    12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd10}, // R10
    '{OP_LK,   27'h2AB,   12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd10},
    '{OP_LK,   27'h7FFFF, 12'h000, 44'h0,     2'd0, 6'h00, 1'b0, 44'h0,     6'h00, 4'd10}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    string tag;
    int    hits;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11", "res_valid", {63'd0, rv1}, 64'd0);
    chk("R11", "res_hit",   {63'd0, rh1}, 64'd0);
    chk("R11", "miss_req",  {63'd0, mq1}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "idle res_valid", {63'd0, rv1}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      tag = $sformatf("R%0d", VT[i].rq);
      case (VT[i].op)
        OP_FILL:  refill(0, VT[i].vpn, VT[i].ppn, VT[i].lvl, VT[i].perm, 0);
        OP_FLUSH: begin
          @(negedge clk); fl1 = 1;
          @(negedge clk); fl1 = 0;
        end
        default: begin
          lookup(0, VT[i].vpn, VT[i].off);
          chk(tag, $sformatf("vec %0d hit", i), {63'd0, o_hit}, {63'd0, VT[i].ehit});
          if (VT[i].ehit) begin
            chk(tag, $sformatf("vec %0d pa", i), {8'd0, o_pa}, {8'd0, VT[i].eppn, VT[i].off});
            chk(tag, $sformatf("vec %0d perm", i), {58'd0, o_pm}, {58'd0, VT[i].eperm});
          end else begin
            chk(tag, $sformatf("vec %0d miss_req", i), {63'd0, o_mreq}, 64'd1);
            chk(tag, $sformatf("vec %0d miss_vpn", i), {37'd0, o_mv}, {37'd0, VT[i].vpn});
          end
        end
      endcase
    end

    // R2 result appears only in the cycle after the request
    @(negedge clk);
    va = {27'h18, 12'h0}; lk1 = 1;
    chk("R2", "no result before edge", {63'd0, rv1}, 64'd0);
    @(negedge clk); lk1 = 0;
    chk("R2", "result after one edge", {63'd0, rv1}, 64'd1);
    @(negedge clk);
    chk("R2", "result drops", {63'd0, rv1}, 64'd0);

    // R10 flush and refill together: refill dropped
    refill(0, 27'h20, 44'h666, 2'd0, 6'h01, 1);
    lookup(0, 27'h20, 12'h0);
    chk("R10", "refill with flush dropped", {63'd0, o_hit}, 64'd0);

    // R12 fully associative, random replacement
    for (int k = 0; k < 4; k++) refill(1, 27'h100 + 27'(k), 44'h900 + 44'(k), 2'd0, 6'h01, 0);
    for (int k = 0; k < 4; k++) begin
      lookup(1, 27'h100 + 27'(k), 12'h0);
      chk("R12", $sformatf("fa resident %0d", k), {63'd0, o_hit}, 64'd1);
      chk("R12", $sformatf("fa pa %0d", k), {8'd0, o_pa}, {8'd0, 44'h900 + 44'(k), 12'h0});
    end
    refill(1, 27'h104, 44'hA00, 2'd0, 6'h01, 0);
    hits = 0;
    for (int k = 0; k < 5; k++) begin
      lookup(1, 27'h100 + 27'(k), 12'h0);
      hits += int'(o_hit);
      if (k == 4) chk("R12", "new entry present", {63'd0, o_hit}, 64'd1);
    end
    chk("R12", "exactly one evicted", 64'(hits), 64'd4);

    done = 1;
    summary();
    $finish;
  end
endmodule